// File: doc/BRIEF.md
# Parallel-Port Drive Block Transfer Sequencer

This block moves a run of bytes between a byte stream and the data register of a drive that sits behind a parallel-port bridge. A transfer is started with a one-cycle strobe. The strobe carries a direction, a read width (nibble or full byte) and a byte count. Bytes move in pairs. The engine drives the 8-bit port data lines and a 6-bit control field through a fixed script of bus steps. Between steps it samples the port status lines, for nibble reads, or the port data lines, for byte reads.

Read bytes leave on a valid/ready source stream and write bytes arrive on a valid/ready sink stream. Back-pressure works this way. When the engine reaches a point that emits a byte, it raises `rd_tvalid` and holds both the data and the whole port bus until `rd_tready` is seen. When it needs a byte to write, it raises `wr_tready` and waits, frozen, until `wr_tvalid`. Stream signals never depend combinationally on the other side's handshake. Each port bus change is held for a programmable number of extra cycles so that slow bridges can settle. A one-cycle `done` pulse closes the transfer.

Top module: `ppx_block_xfer`

## Requirements
- R1: After reset, `busy`, `done`, `rd_tvalid` and `wr_tready` are 0, the port control field is 0x0C and the port data lines are 0x00.
- R2: A transfer moves floor(count/2) byte pairs. An odd last byte is neither emitted on a read nor accepted on a write.
- R3: A nibble read (dir_write=0, mode8=0) opens with data 0x48, then control 0x0E, then 0x06. Each pair steps control through 0x07, 0x06 and 0x02, drives data 0x58, sets control to 0x00 and drives data 0x48. The transfer closes with control 0x0C.
- R4: In a nibble read, status is sampled four times per pair: S1 after control 0x02, S2 after data 0x58, S3 after control 0x00 and S4 after data 0x48. The first byte emitted is {S3[7:4],S4[7:4]}^0x88 and the second is {S2[7:4],S1[7:4]}^0x88.
- R5: A byte read (mode8=1) opens with data 0x58, control 0x0E and 0x06. Each pair steps control through 0x27, 0x26, 0x22 (data sample X) and 0x20 (data sample Y), and emits Y then X. The transfer closes with control 0x26, then 0x0C.
- R6: A write (dir_write=1) opens with data 0x88, control 0x0E and 0x06. For a pair accepted as (P, Q) in stream order, it drives data Q, control 0x0E, 0x06, then data P, control 0x07, 0x06. The transfer closes with control 0x0C.
- R7: While busy, successive port bus changes are at least hold_cycles+1 cycles apart. Data and control never change in the same cycle.
- R8: A raised `rd_tvalid` stays high with stable `rd_tdata` until accepted. `wr_tready` is high only while the engine waits for a write byte, and the port bus does not move while a stream handshake is pending.
- R9: `done` is high for exactly one cycle, with `busy` low, after the closing step. A `start` while busy is ignored.
- R10: A `start` in the cycle that `done` is high begins a new transfer.
- R11: A count below 2 runs only the opening and closing steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (taken when idle) |
| dir_write | input | 1 | 1 = write to drive, 0 = read |
| mode8 | input | 1 | Read width: 1 = byte, 0 = nibble |
| byte_count | input | CNT_W | Bytes to move (odd last byte dropped) |
| hold_cycles | input | HOLD_W | Extra cycles each bus change is held |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| rd_tdata | output | 8 | Read byte |
| rd_tvalid | output | 1 | Read byte valid |
| rd_tready | input | 1 | Sink accepts read byte |
| wr_tdata | input | 8 | Write byte |
| wr_tvalid | input | 1 | Write byte valid |
| wr_tready | output | 1 | Engine accepts write byte |
| pp_data_out | output | 8 | Port data lines |
| pp_ctrl_out | output | 6 | Port control field |
| pp_status_in | input | 8 | Port status lines (high nibble used) |
| pp_data_in | input | 8 | Port data lines read back |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is stream back-pressure and the expiry of a bus hold. The source sink drops `rd_tready` on two of every three cycles, and the write source offers data on alternate cycles. Hold values differ from vector to vector, so that emit and take steps are reached both right after a hold expires and mid-stall. The bus trace, the spacing of changes and the byte order are judged against a device model. The second pair is the `done` pulse and a new `start`. The bench raises `start` in the very cycle it sees `done`, then checks `busy` on the next cycle and checks the whole second transfer.

// File: rtl/ppx_pkg.sv
package ppx_pkg;
  localparam int BYTE_W = 8;
  localparam int CTRL_W = 6;
  localparam int SLOTS  = 4;
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int IDX_W  = 4;

  typedef enum logic [3:0] {
    OP_END, OP_DRV_D, OP_DRV_C, OP_DRV_SLOT,
    OP_SMP_ST, OP_SMP_DT, OP_EMIT_RAW, OP_EMIT_MRG, OP_TAKE
  } op_e;

  typedef enum logic [1:0] {SEC_PRE, SEC_BODY, SEC_POST} sec_e;
  typedef enum logic [1:0] {XF_RD4, XF_RD8, XF_WR} xf_e;

  typedef struct packed {
    op_e               op;
    logic [BYTE_W-1:0] val;
    logic [SLOT_W-1:0] sa;
    logic [SLOT_W-1:0] sb;
  } step_t;

  function automatic step_t mk(op_e o, logic [BYTE_W-1:0] v,
                               logic [SLOT_W-1:0] a, logic [SLOT_W-1:0] b);
    step_t s;
    s.op = o; s.val = v; s.sa = a; s.sb = b;
    return s;
  endfunction
endpackage

// File: rtl/ppx_nibble_merge.sv
module ppx_nibble_merge
  import ppx_pkg::*;
(
  input  logic [BYTE_W-1:0] lo_smp,
  input  logic [BYTE_W-1:0] hi_smp,
  output logic [BYTE_W-1:0] merged
);
  localparam int NIB = BYTE_W / 2;
  always_comb merged = {hi_smp[BYTE_W-1 -: NIB], lo_smp[BYTE_W-1 -: NIB]} ^ 8'h88;
endmodule

// File: rtl/ppx_hold_timer.sv
module ppx_hold_timer #(
  parameter int HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [HOLD_W-1:0] hold,
  output logic              active
);
  logic [HOLD_W-1:0] cnt_q;
  always_ff @(posedge clk) begin
    if (!rst_n)           cnt_q <= '0;
    else if (load)        cnt_q <= hold;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end
  assign active = (cnt_q != '0);
endmodule

// File: rtl/ppx_step_rom.sv
module ppx_step_rom
  import ppx_pkg::*;
(
  input  xf_e              xf,
  input  sec_e             sec,
  input  logic [IDX_W-1:0] idx,
  output step_t            st
);
  logic [BYTE_W-1:0] open_d;
  always_comb begin
    unique case (xf)
      XF_RD4:  open_d = 8'h48;
      XF_RD8:  open_d = 8'h58;
      default: open_d = 8'h88;
    endcase
  end

  always_comb begin
    st = mk(OP_END, 8'h00, 2'd0, 2'd0);
    unique case (sec)
      SEC_PRE: begin
        unique case (idx)
          4'd0:    st = mk(OP_DRV_D, open_d, 2'd0, 2'd0);
          4'd1:    st = mk(OP_DRV_C, 8'h0E, 2'd0, 2'd0);
          4'd2:    st = mk(OP_DRV_C, 8'h06, 2'd0, 2'd0);
          default: st = mk(OP_END, 8'h00, 2'd0, 2'd0);
        endcase
      end
      SEC_BODY: begin
        unique case (xf)
          XF_RD4: begin
            unique case (idx)
              4'd0:    st = mk(OP_DRV_C, 8'h07, 2'd0, 2'd0);
              4'd1:    st = mk(OP_DRV_C, 8'h06, 2'd0, 2'd0);
              4'd2:    st = mk(OP_DRV_C, 8'h02, 2'd0, 2'd0);
              4'd3:    st = mk(OP_SMP_ST, 8'h00, 2'd0, 2'd0);
              4'd4:    st = mk(OP_DRV_D, 8'h58, 2'd0, 2'd0);
              4'd5:    st = mk(OP_SMP_ST, 8'h00, 2'd1, 2'd0);
              4'd6:    st = mk(OP_DRV_C, 8'h00, 2'd0, 2'd0);
              4'd7:    st = mk(OP_SMP_ST, 8'h00, 2'd2, 2'd0);
              4'd8:    st = mk(OP_DRV_D, 8'h48, 2'd0, 2'd0);
              4'd9:    st = mk(OP_SMP_ST, 8'h00, 2'd3, 2'd0);
              4'd10:   st = mk(OP_EMIT_MRG, 8'h00, 2'd3, 2'd2);
              4'd11:   st = mk(OP_EMIT_MRG, 8'h00, 2'd0, 2'd1);
              default: st = mk(OP_END, 8'h00, 2'd0, 2'd0);
            endcase
          end
          XF_RD8: begin
            unique case (idx)
              4'd0:    st = mk(OP_DRV_C, 8'h27, 2'd0, 2'd0);
              4'd1:    st = mk(OP_DRV_C, 8'h26, 2'd0, 2'd0);
              4'd2:    st = mk(OP_DRV_C, 8'h22, 2'd0, 2'd0);
              4'd3:    st = mk(OP_SMP_DT, 8'h00, 2'd0, 2'd0);
              4'd4:    st = mk(OP_DRV_C, 8'h20, 2'd0, 2'd0);
              4'd5:    st = mk(OP_SMP_DT, 8'h00, 2'd1, 2'd0);
              4'd6:    st = mk(OP_EMIT_RAW, 8'h00, 2'd1, 2'd0);
              4'd7:    st = mk(OP_EMIT_RAW, 8'h00, 2'd0, 2'd0);
              default: st = mk(OP_END, 8'h00, 2'd0, 2'd0);
            endcase
          end
          default: begin
            unique case (idx)
              4'd0:    st = mk(OP_TAKE, 8'h00, 2'd0, 2'd0);
              4'd1:    st = mk(OP_TAKE, 8'h00, 2'd1, 2'd0);
              4'd2:    st = mk(OP_DRV_SLOT, 8'h00, 2'd1, 2'd0);
              4'd3:    st = mk(OP_DRV_C, 8'h0E, 2'd0, 2'd0);
              4'd4:    st = mk(OP_DRV_C, 8'h06, 2'd0, 2'd0);
              4'd5:    st = mk(OP_DRV_SLOT, 8'h00, 2'd0, 2'd0);
              4'd6:    st = mk(OP_DRV_C, 8'h07, 2'd0, 2'd0);
              4'd7:    st = mk(OP_DRV_C, 8'h06, 2'd0, 2'd0);
              default: st = mk(OP_END, 8'h00, 2'd0, 2'd0);
            endcase
          end
        endcase
      end
      default: begin
        if (xf == XF_RD8) begin
          unique case (idx)
            4'd0:    st = mk(OP_DRV_C, 8'h26, 2'd0, 2'd0);
            4'd1:    st = mk(OP_DRV_C, 8'h0C, 2'd0, 2'd0);
            default: st = mk(OP_END, 8'h00, 2'd0, 2'd0);
          endcase
        end else begin
          unique case (idx)
            4'd0:    st = mk(OP_DRV_C, 8'h0C, 2'd0, 2'd0);
            default: st = mk(OP_END, 8'h00, 2'd0, 2'd0);
          endcase
        end
      end
    endcase
  end
endmodule

// File: rtl/ppx_block_xfer.sv
module ppx_block_xfer
  import ppx_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              dir_write,
  input  logic              mode8,
  input  logic [CNT_W-1:0]  byte_count,
  input  logic [HOLD_W-1:0] hold_cycles,
  output logic              busy,
  output logic              done,
  output logic [7:0]        rd_tdata,
  output logic              rd_tvalid,
  input  logic              rd_tready,
  input  logic [7:0]        wr_tdata,
  input  logic              wr_tvalid,
  output logic              wr_tready,
  output logic [7:0]        pp_data_out,
  output logic [5:0]        pp_ctrl_out,
  input  logic [7:0]        pp_status_in,
  input  logic [7:0]        pp_data_in
);
  localparam int PAIR_W = CNT_W - 1;

  logic              busy_q, done_q;
  xf_e               xf_q;
  sec_e              sec_q;
  logic [IDX_W-1:0]  idx_q;
  logic [PAIR_W-1:0] pairs_q;
  logic [BYTE_W-1:0] slot_q [SLOTS];
  logic [BYTE_W-1:0] pp_data_q;
  logic [CTRL_W-1:0] pp_ctrl_q;

  step_t             st;
  logic              hold_active, go, drive_step;
  logic [BYTE_W-1:0] merged;

  ppx_step_rom u_rom (.xf(xf_q), .sec(sec_q), .idx(idx_q), .st(st));

  ppx_hold_timer #(.HOLD_W(HOLD_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(drive_step),
    .hold(hold_cycles), .active(hold_active)
  );

  ppx_nibble_merge u_merge (
    .lo_smp(slot_q[st.sa]), .hi_smp(slot_q[st.sb]), .merged(merged)
  );

  assign go         = busy_q && !hold_active;
  assign drive_step = go && (st.op inside {OP_DRV_D, OP_DRV_C, OP_DRV_SLOT});
  assign rd_tvalid  = go && (st.op inside {OP_EMIT_RAW, OP_EMIT_MRG});
  assign rd_tdata   = (st.op == OP_EMIT_MRG) ? merged : slot_q[st.sa];
  assign wr_tready  = go && (st.op == OP_TAKE);
  assign busy        = busy_q;
  assign done        = done_q;
  assign pp_data_out = pp_data_q;
  assign pp_ctrl_out = pp_ctrl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      xf_q      <= XF_RD4;
      sec_q     <= SEC_PRE;
      idx_q     <= '0;
      pairs_q   <= '0;
      pp_data_q <= 8'h00;
      pp_ctrl_q <= 6'h0C;
      for (int i = 0; i < SLOTS; i++) slot_q[i] <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q  <= 1'b1;
          xf_q    <= dir_write ? XF_WR : (mode8 ? XF_RD8 : XF_RD4);
          sec_q   <= SEC_PRE;
          idx_q   <= '0;
          pairs_q <= byte_count[CNT_W-1:1];
        end
      end else if (go) begin
        unique case (st.op)
          OP_DRV_D: begin
            pp_data_q <= st.val;
            idx_q     <= idx_q + 1'b1;
          end
          OP_DRV_SLOT: begin
            pp_data_q <= slot_q[st.sa];
            idx_q     <= idx_q + 1'b1;
          end
          OP_DRV_C: begin
            pp_ctrl_q <= st.val[CTRL_W-1:0];
            idx_q     <= idx_q + 1'b1;
          end
          OP_SMP_ST: begin
            slot_q[st.sa] <= pp_status_in;
            idx_q         <= idx_q + 1'b1;
          end
          OP_SMP_DT: begin
            slot_q[st.sa] <= pp_data_in;
            idx_q         <= idx_q + 1'b1;
          end
          OP_EMIT_RAW, OP_EMIT_MRG: begin
            if (rd_tready) idx_q <= idx_q + 1'b1;
          end
          OP_TAKE: begin
            if (wr_tvalid) begin
              slot_q[st.sa] <= wr_tdata;
              idx_q         <= idx_q + 1'b1;
            end
          end
          default: begin
            idx_q <= '0;
            unique case (sec_q)
              SEC_PRE:  sec_q <= (pairs_q != '0) ? SEC_BODY : SEC_POST;
              SEC_BODY: begin
                pairs_q <= pairs_q - 1'b1;
                if (pairs_q == PAIR_W'(1)) sec_q <= SEC_POST;
              end
              default: begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
              end
            endcase
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/ppx_block_xfer_chk.sv
module ppx_block_xfer_chk #(
  parameter int HOLD_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic [7:0]        rd_tdata,
  input logic              rd_tvalid,
  input logic              rd_tready,
  input logic              wr_tready,
  input logic [7:0]        pp_data_out,
  input logic [5:0]        pp_ctrl_out,
  input logic [HOLD_W-1:0] hold_cycles
);
  logic [13:0] prev_bus_q;
  logic [15:0] gap_q;
  logic        armed_q;
  logic        bus_moved;

  assign bus_moved = ({pp_data_out, pp_ctrl_out} != prev_bus_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_bus_q <= {8'h00, 6'h0C};
      gap_q      <= '0;
      armed_q    <= 1'b0;
    end else begin
      prev_bus_q <= {pp_data_out, pp_ctrl_out};
      if (bus_moved)            gap_q <= '0;
      else if (gap_q != 16'hFFFF) gap_q <= gap_q + 1'b1;
      if (!busy)          armed_q <= 1'b0;
      else if (bus_moved) armed_q <= 1'b1;
    end
  end

  // R7
  hold_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && armed_q && bus_moved) |-> (gap_q >= 16'(hold_cycles)));

  // R7
  one_lane_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!$stable(pp_data_out) && !$stable(pp_ctrl_out)));

  // R8
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_tvalid && !rd_tready) |=> (rd_tvalid && $stable(rd_tdata)));

  // R8
  rd_bus_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_tvalid && !rd_tready) |=> ($stable(pp_data_out) && $stable(pp_ctrl_out)));

  // R8
  one_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_tvalid && wr_tready));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!rd_tvalid && !wr_tready));

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind ppx_block_xfer ppx_block_xfer_chk #(.HOLD_W(HOLD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .rd_tdata(rd_tdata), .rd_tvalid(rd_tvalid), .rd_tready(rd_tready),
  .wr_tready(wr_tready), .pp_data_out(pp_data_out),
  .pp_ctrl_out(pp_ctrl_out), .hold_cycles(hold_cycles)
);

// File: tb/ppx_block_xfer_test.sv
`timescale 1ns/1ps
module ppx_block_xfer_test;
  localparam int CNT_W  = 16;
  localparam int HOLD_W = 8;

  typedef struct packed {
    logic       wr;
    logic       m8;
    logic [7:0] cnt;
    logic [3:0] hold;
    logic       bp;
    logic [7:0] seed;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 8'd4, 4'd0, 1'b0, 8'h00},
    '{1'b0, 1'b0, 8'd6, 4'd2, 1'b1, 8'h5A},
    '{1'b0, 1'b1, 8'd4, 4'd0, 1'b0, 8'h33},
    '{1'b0, 1'b1, 8'd8, 4'd3, 1'b1, 8'hC4},
    '{1'b1, 1'b0, 8'd4, 4'd0, 1'b0, 8'h17},
    '{1'b1, 1'b0, 8'd6, 4'd1, 1'b1, 8'hE9}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, dir_write = 1'b0, mode8 = 1'b0;
  logic [CNT_W-1:0]  byte_count = '0;
  logic [HOLD_W-1:0] hold_cycles = '0;
  logic busy, done, rd_tvalid, rd_tready = 1'b1, wr_tvalid = 1'b0, wr_tready;
  logic [7:0] rd_tdata, wr_tdata = 8'h00, pp_data_out, pp_status_in, pp_data_in;
  logic [5:0] pp_ctrl_out;

  always #2 clk = ~clk;

  ppx_block_xfer #(.CNT_W(CNT_W), .HOLD_W(HOLD_W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .dir_write(dir_write),
    .mode8(mode8), .byte_count(byte_count), .hold_cycles(hold_cycles),
    .busy(busy), .done(done), .rd_tdata(rd_tdata), .rd_tvalid(rd_tvalid),
    .rd_tready(rd_tready), .wr_tdata(wr_tdata), .wr_tvalid(wr_tvalid),
    .wr_tready(wr_tready), .pp_data_out(pp_data_out), .pp_ctrl_out(pp_ctrl_out),
    .pp_status_in(pp_status_in), .pp_data_in(pp_data_in)
  );

  int n_chk = 0, n_fail = 0;
  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // device model and monitor state
  logic [7:0] seed = 8'h00;
  int  dev_k = -1;
  logic mon_on = 1'b0, bp = 1'b0;
  logic [13:0] rec [256];
  logic [13:0] exp_tr [256];
  int rec_n = 0, exp_n = 0;
  logic [7:0] rx [64];
  int rx_n = 0, wr_ptr = 0, cyc = 0, cyc_since = 0, gap_bad = 0, stab_bad = 0;
  logic armed = 1'b0, wr_pend = 1'b0, rd_wait = 1'b0;
  logic [7:0] rd_last = 8'h00;
  logic [13:0] last_bus = {8'h00, 6'h0C};
  logic [7:0] cur_d;
  logic [5:0] cur_c;

  function automatic logic [7:0] dev_byte(int i, logic [7:0] s);
    return 8'((i * 29 + 11) ^ s);
  endfunction
  function automatic logic [7:0] src_byte(int i, logic [7:0] s);
    return 8'((i * 53 + 7) ^ s);
  endfunction

  logic [7:0] dv_first, dv_second;
  always_comb begin
    dv_first  = dev_byte(2 * (dev_k < 0 ? 0 : dev_k), seed);
    dv_second = dev_byte(2 * (dev_k < 0 ? 0 : dev_k) + 1, seed);
    unique case ({pp_ctrl_out[1], pp_data_out[4]})
      2'b10:   pp_status_in = {dv_second[3:0] ^ 4'h8, 4'h0};
      2'b11:   pp_status_in = {dv_second[7:4] ^ 4'h8, 4'h0};
      2'b01:   pp_status_in = {dv_first[7:4] ^ 4'h8, 4'h0};
      default: pp_status_in = {dv_first[3:0] ^ 4'h8, 4'h0};
    endcase
    pp_data_in = (pp_ctrl_out == 6'h22) ? dv_second : dv_first;
  end

  always @(negedge clk) begin
    cyc++;
    if (mon_on) begin
      if ({pp_data_out, pp_ctrl_out} != last_bus) begin
        if (armed && cyc_since < int'(hold_cycles)) gap_bad++;
        if (rec_n < 256) rec[rec_n] = {pp_data_out, pp_ctrl_out};
        rec_n++;
        last_bus = {pp_data_out, pp_ctrl_out};
        cyc_since = 0;
        armed = 1'b1;
        if (pp_ctrl_out == 6'h07 || pp_ctrl_out == 6'h27) dev_k++;
      end else cyc_since++;
      if (rd_wait && !(rd_tvalid && rd_tdata == rd_last)) stab_bad++;
      rd_tready = !bp || (cyc % 3 == 0);
      if (rd_tvalid && rd_tready) begin
        if (rx_n < 64) rx[rx_n] = rd_tdata;
        rx_n++;
      end
      rd_wait = rd_tvalid && !rd_tready;
      rd_last = rd_tdata;
      if (wr_pend) wr_ptr++;
      wr_tdata  = src_byte(wr_ptr, seed);
      wr_tvalid = dir_write && (!bp || (cyc % 2 == 0));
      wr_pend   = wr_tvalid && wr_tready;
    end
  end

  task automatic ex(logic [7:0] d, logic [5:0] c);
    if (d != cur_d || c != cur_c) begin
      exp_tr[exp_n] = {d, c};
      exp_n++;
      cur_d = d; cur_c = c;
    end
  endtask
  task automatic exd(logic [7:0] d); ex(d, cur_c); endtask
  task automatic exc(logic [5:0] c); ex(cur_d, c); endtask

  task automatic begin_xfer(logic wr, logic m8, int cnt, int hold, logic b, logic [7:0] s);
    int np = cnt / 2;
    dir_write = wr; mode8 = m8; byte_count = CNT_W'(cnt);
    hold_cycles = HOLD_W'(hold); bp = b; seed = s;
    rec_n = 0; exp_n = 0; rx_n = 0; wr_ptr = 0; wr_pend = 1'b0;
    dev_k = -1; armed = 1'b0; cyc_since = 0; gap_bad = 0; stab_bad = 0;
    rd_wait = 1'b0; mon_on = 1'b1;
    cur_d = pp_data_out; cur_c = pp_ctrl_out; last_bus = {cur_d, cur_c};
    if (wr) begin
      exd(8'h88); exc(6'h0E); exc(6'h06);
      for (int k = 0; k < np; k++) begin
        exd(src_byte(2 * k + 1, s)); exc(6'h0E); exc(6'h06);
        exd(src_byte(2 * k, s));     exc(6'h07); exc(6'h06);
      end
      exc(6'h0C);
    end else if (m8) begin
      exd(8'h58); exc(6'h0E); exc(6'h06);
      for (int k = 0; k < np; k++) begin
        exc(6'h27); exc(6'h26); exc(6'h22); exc(6'h20);
      end
      exc(6'h26); exc(6'h0C);
    end else begin
      exd(8'h48); exc(6'h0E); exc(6'h06);
      for (int k = 0; k < np; k++) begin
        exc(6'h07); exc(6'h06); exc(6'h02); exd(8'h58); exc(6'h00); exd(8'h48);
      end
      exc(6'h0C);
    end
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(string req);
    int t = 0;
    while (!done && t < 5000) begin @(negedge clk); t++; end
    chk(req, "done reached before timeout", int'(done), 1);
  endtask

  task automatic finish_xfer(string seq_req, string cnt_req, int cnt);
    int np = cnt / 2, bad = 0;
    wait_done("R9");
    chk("R9", "busy low with done", int'(busy), 0);
    @(negedge clk);
    chk("R9", "done lasts one cycle", int'(done), 0);
    mon_on = 1'b0;
    chk(seq_req, "bus change count", rec_n, exp_n);
    for (int i = 0; i < exp_n && i < rec_n; i++)
      if (rec[i] != exp_tr[i]) begin
        bad++;
        $display("FAIL %s bus step %0d: actual 0x%0h expected 0x%0h", seq_req, i, rec[i], exp_tr[i]);
      end
    chk(seq_req, "bus trace mismatches", bad, 0);
    chk("R7", "hold spacing violations", gap_bad, 0);
    chk("R8", "read stream stability violations", stab_bad, 0);
    if (dir_write) begin
      chk(cnt_req, "write bytes consumed", wr_ptr, 2 * np);
      chk("R8", "wr_tready low after transfer", int'(wr_tready), 0);
    end else begin
      chk(cnt_req, "read bytes emitted", rx_n, 2 * np);
      bad = 0;
      for (int i = 0; i < rx_n && i < 2 * np; i++)
        if (rx[i] != dev_byte(i, seed)) begin
          bad++;
          $display("FAIL %s read byte %0d: actual 0x%0h expected 0x%0h",
                   mode8 ? "R5" : "R4", i, rx[i], dev_byte(i, seed));
        end
      chk(mode8 ? "R5" : "R4", "read byte mismatches", bad, 0);
    end
  endtask

  initial begin
    #(4 * 150000);
    chk("WDOG", "watchdog expired", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "busy in reset", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "done", int'(done), 0);
    chk("R1", "rd_tvalid", int'(rd_tvalid), 0);
    chk("R1", "wr_tready", int'(wr_tready), 0);
    chk("R1", "control idle value", int'(pp_ctrl_out), 'h0C);
    chk("R1", "data idle value", int'(pp_data_out), 'h00);

    for (int v = 0; v < NV; v++) begin
      vec_t t = VECS[v];
      begin_xfer(t.wr, t.m8, int'(t.cnt), int'(t.hold), t.bp, t.seed);
      finish_xfer(t.wr ? "R6" : (t.m8 ? "R5" : "R3"), "R2", int'(t.cnt));
      repeat (2) @(negedge clk);
    end

    // R2 odd count on a nibble read and on a write
    begin_xfer(1'b0, 1'b0, 5, 1, 1'b0, 8'h71);
    finish_xfer("R3", "R2", 5);
    begin_xfer(1'b1, 1'b0, 3, 0, 1'b0, 8'h2C);
    finish_xfer("R6", "R2", 3);

    // R11 count below two on a byte read
    begin_xfer(1'b0, 1'b1, 1, 0, 1'b0, 8'h44);
    finish_xfer("R11", "R11", 1);

    // R9 start while busy is ignored
    begin_xfer(1'b0, 1'b1, 4, 1, 1'b0, 8'h9D);
    repeat (4) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    finish_xfer("R9", "R9", 4);

    // R10 start in the done cycle
    begin_xfer(1'b0, 1'b0, 2, 0, 1'b0, 8'h0F);
    wait_done("R10");
    begin_xfer(1'b1, 1'b0, 2, 0, 1'b0, 8'hB2);
    chk("R10", "busy after start in done cycle", int'(busy), 1);
    finish_xfer("R10", "R10", 2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule